// File: doc/BRIEF.md
# Interleaved Converter Result Multiplexer

This block is the output stage of a time-interleaved converter built from a ring of parallel conversion sections. Each clock one section takes a sample, in strict round-robin order. The sections finish at different times, and each hands its result to this block by raising a transfer strobe together with its own index. The block keeps every result in a holding slot for that section. It then delivers the words in sample order on a registered output bus, each word exactly a fixed number of clocks after its sample was taken.

Each result word is wider than the output byte. A result that fits in the byte is presented as plain unsigned binary, with the overrange flag low. A larger result raises the overrange flag and forces every byte bit to one. A data-valid strobe marks each cycle that carries a fresh word. An active-low output enable floats the byte and the overrange flag, but the pipeline and the data-valid strobe keep running.

A small sequencer with two states sets the timing. FILL is entered at reset. In FILL a fill counter runs and nothing is read out. The transition FILL to RUN fires at the clock edge that ends cycle LAT-2. RUN has one transition, RUN to RUN, and it holds until the next reset. In RUN, every cycle reads the slot of the section that sampled LAT-1 cycles earlier into the output register.

Top module: `interleave_result_mux`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the FSM is in FILL, `dav_o` is 0, and the registered byte and overrange bit are 0.
- R2: Cycle 0 is the first cycle after reset. The sample of cycle k is taken by section k mod NSEC. Its word is on the outputs in cycle k+LAT (LAT=12), and `dav_o` is 0 in cycles 0 to LAT-1.
- R3: A result code of 255 or less appears unchanged on `d_o` as straight binary, with bit 0 as the LSB, and `ovr_o` is 0.
- R4: A result code of 256 to 511 sets `ovr_o` to 1 and drives `d_o` to 8'hFF.
- R5: A section may transfer its result in any cycle from k to k+LAT-1 inclusive. A transfer made in cycle k+LAT-1 goes straight through to the output register in that same cycle.
- R6: While `oe_n` is 1, `bus_drv` is 0 and `d_o`/`ovr_o` are high-impedance. `dav_o` keeps running. After `oe_n` returns to 0, the words in sample order continue on the bus without any gap.
- R7: When every section transfers in time, `dav_o` is 1 in every cycle from cycle LAT on.
- R8: If no result for sample k has been transferred by cycle k+LAT-1, then `dav_o` is 0 in cycle k+LAT, and `d_o` and `ovr_o` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all registers update on its rising edge |
| rst | input | 1 | Asynchronous reset, active high |
| sec_res | input | NSEC*RES_W (144) | Results of all sections side by side; section i occupies bits i*RES_W upward |
| xfer | input | 1 | Transfer strobe: the section named by `xfer_idx` hands over its result this cycle |
| xfer_idx | input | $clog2(NSEC) (4) | Index of the transferring section |
| oe_n | input | 1 | Output enable, active low |
| d_o | output | OUT_W (8) | Tri-state result byte, straight binary |
| ovr_o | output | 1 | Tri-state overrange flag |
| dav_o | output | 1 | Data-valid strobe for the word on the bus |
| bus_drv | output | 1 | High while `d_o` and `ovr_o` are driven |

## Verification
The bench builds the block with its default parameters: 16 sections, 9-bit results, an 8-bit byte and a latency of 12. Each stream runs 40 samples, so the read pointer wraps around the section ring more than twice. Transfer delays of 0, 5 to 8 and 11 cycles reach both ends of the allowed window, including the same-cycle bypass. The value patterns step through the clamp boundary at 255/256, the all-ones code 511, a withheld transfer, and an enable window in the middle of a stream.

// File: rtl/irm_pkg.sv
package irm_pkg;
    typedef enum logic [0:0] {
        ST_FILL = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_t;
endpackage

// File: rtl/irm_sequencer.sv
module irm_sequencer
    import irm_pkg::*;
#(
    parameter int NSEC = 16,
    parameter int LAT  = 12
) (
    input  logic                     clk,
    input  logic                     rst,
    output logic                     run,
    output logic [$clog2(NSEC)-1:0]  rd_ptr
);
    localparam int IDX_W = $clog2(NSEC);
    localparam int CNT_W = (LAT > 2) ? $clog2(LAT) : 1;
    localparam int BACK  = (LAT - 1) % NSEC;

    seq_state_t          state_q, state_d;
    logic [CNT_W-1:0]    fill_q;
    logic [IDX_W-1:0]    samp_q;

    // state register, fill counter, sampling pointer
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            state_q <= ST_FILL;
            fill_q  <= '0;
            samp_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_FILL)
                fill_q <= fill_q + 1'b1;
            if (samp_q == IDX_W'(NSEC - 1))
                samp_q <= '0;
            else
                samp_q <= samp_q + 1'b1;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FILL: if (fill_q == CNT_W'(LAT - 2)) state_d = ST_RUN;
            ST_RUN:  state_d = ST_RUN;
        endcase
    end

    // outputs
    always_comb begin
        run = 1'b0;
        unique case (state_q)
            ST_FILL: run = 1'b0;
            ST_RUN:  run = 1'b1;
        endcase
        if (samp_q >= IDX_W'(BACK))
            rd_ptr = samp_q - IDX_W'(BACK);
        else
            rd_ptr = IDX_W'(samp_q + IDX_W'(NSEC - BACK));
    end
endmodule

// File: rtl/irm_slot_bank.sv
module irm_slot_bank #(
    parameter int NSEC  = 16,
    parameter int RES_W = 9
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NSEC*RES_W-1:0]    sec_res,
    input  logic                     xfer,
    input  logic [$clog2(NSEC)-1:0]  xfer_idx,
    input  logic                     rd_en,
    input  logic [$clog2(NSEC)-1:0]  rd_idx,
    output logic [RES_W-1:0]         rd_word,
    output logic                     rd_fresh
);
    localparam int IDX_W = $clog2(NSEC);

    logic [RES_W-1:0] slice   [NSEC];
    logic [RES_W-1:0] hold_q  [NSEC];
    logic [NSEC-1:0]  fresh_q;
    logic             bypass;

    for (genvar i = 0; i < NSEC; i++) begin : g_slot
        logic wr_hit, rd_hit;
        assign slice[i] = sec_res[i*RES_W +: RES_W];
        assign wr_hit   = xfer  && (xfer_idx == IDX_W'(i));
        assign rd_hit   = rd_en && (rd_idx   == IDX_W'(i));

        always_ff @(posedge clk or posedge rst) begin
            if (rst) begin
                hold_q[i]  <= '0;
                fresh_q[i] <= 1'b0;
            end else begin
                if (wr_hit)
                    hold_q[i] <= slice[i];
                if (wr_hit && !rd_hit)
                    fresh_q[i] <= 1'b1;
                else if (rd_hit)
                    fresh_q[i] <= 1'b0;
            end
        end
    end

    // same-cycle transfer into the slot being read goes straight through
    assign bypass = xfer && (xfer_idx == rd_idx);

    always_comb begin
        rd_word  = bypass ? slice[xfer_idx] : hold_q[rd_idx];
        rd_fresh = rd_en && (bypass || fresh_q[rd_idx]);
    end
endmodule

// File: rtl/irm_out_stage.sv
module irm_out_stage #(
    parameter int RES_W = 9,
    parameter int OUT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld,
    input  logic [RES_W-1:0]  word,
    output logic [OUT_W-1:0]  byte_q,
    output logic              ovr_q,
    output logic              dav_q
);
    logic             ovr_d;
    logic [OUT_W-1:0] byte_d;

    always_comb begin
        ovr_d  = |word[RES_W-1:OUT_W];
        byte_d = ovr_d ? {OUT_W{1'b1}} : word[OUT_W-1:0];
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            byte_q <= '0;
            ovr_q  <= 1'b0;
            dav_q  <= 1'b0;
        end else begin
            dav_q <= ld;
            if (ld) begin
                byte_q <= byte_d;
                ovr_q  <= ovr_d;
            end
        end
    end
endmodule

// File: rtl/interleave_result_mux.sv
module interleave_result_mux #(
    parameter int NSEC  = 16,
    parameter int RES_W = 9,
    parameter int OUT_W = 8,
    parameter int LAT   = 12
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NSEC*RES_W-1:0]    sec_res,
    input  logic                     xfer,
    input  logic [$clog2(NSEC)-1:0]  xfer_idx,
    input  logic                     oe_n,
    output logic [OUT_W-1:0]         d_o,
    output logic                     ovr_o,
    output logic                     dav_o,
    output logic                     bus_drv
);
    localparam int IDX_W = $clog2(NSEC);

    logic              run;
    logic [IDX_W-1:0]  rd_ptr;
    logic [RES_W-1:0]  rd_word;
    logic              rd_fresh;
    logic [OUT_W-1:0]  byte_q;
    logic              ovr_q;
    logic              dav_q;

    irm_sequencer #(.NSEC(NSEC), .LAT(LAT)) u_seq (
        .clk    (clk),
        .rst    (rst),
        .run    (run),
        .rd_ptr (rd_ptr)
    );

    irm_slot_bank #(.NSEC(NSEC), .RES_W(RES_W)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .sec_res  (sec_res),
        .xfer     (xfer),
        .xfer_idx (xfer_idx),
        .rd_en    (run),
        .rd_idx   (rd_ptr),
        .rd_word  (rd_word),
        .rd_fresh (rd_fresh)
    );

    irm_out_stage #(.RES_W(RES_W), .OUT_W(OUT_W)) u_out (
        .clk    (clk),
        .rst    (rst),
        .ld     (rd_fresh),
        .word   (rd_word),
        .byte_q (byte_q),
        .ovr_q  (ovr_q),
        .dav_q  (dav_q)
    );

    assign bus_drv = !oe_n;
    assign d_o     = bus_drv ? byte_q : {OUT_W{1'bz}};
    assign ovr_o   = bus_drv ? ovr_q  : 1'bz;
    assign dav_o   = dav_q;
endmodule

// File: rtl/irm_chk.sv
module irm_chk #(
    parameter int OUT_W = 8,
    parameter int LAT   = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              oe_n,
    input logic              bus_drv,
    input logic              dav_o,
    input logic [OUT_W-1:0]  byte_q,
    input logic              ovr_q
);
    localparam int CW = $clog2(LAT + 1);
    logic [CW-1:0] since_q;

    always_ff @(posedge clk or posedge rst) begin
        if (rst)
            since_q <= '0;
        else if (since_q != CW'(LAT))
            since_q <= since_q + 1'b1;
    end

    // R2: no valid word before the latency has elapsed
    a_r2_quiet_fill: assert property (@(posedge clk) disable iff (rst)
        (since_q < CW'(LAT)) |-> !dav_o);

    // R4: overrange forces all ones
    a_r4_clamp: assert property (@(posedge clk) disable iff (rst)
        ovr_q |-> (byte_q == {OUT_W{1'b1}}));

    // R6: enable governs the drivers
    a_r6_float: assert property (@(posedge clk) disable iff (rst)
        oe_n |-> !bus_drv);
    a_r6_drive: assert property (@(posedge clk) disable iff (rst)
        !oe_n |-> bus_drv);

    // R8: no fresh word means the bus contents stay put
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        !dav_o |-> $stable({ovr_q, byte_q}));
endmodule

bind interleave_result_mux irm_chk #(.OUT_W(OUT_W), .LAT(LAT)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .oe_n    (oe_n),
    .bus_drv (bus_drv),
    .dav_o   (dav_o),
    .byte_q  (byte_q),
    .ovr_q   (ovr_q)
);

// File: tb/interleave_result_mux_test.sv
module interleave_result_mux_test;
    localparam int CLK_P = 10;
    localparam int NSEC  = 16;
    localparam int RES_W = 9;
    localparam int OUT_W = 8;
    localparam int LAT   = 12;
    localparam int NSAMP = 40;

    logic                  clk = 1'b0;
    logic                  rst = 1'b1;
    logic [NSEC*RES_W-1:0] sec_res = '0;
    logic                  xfer = 1'b0;
    logic [3:0]            xfer_idx = '0;
    logic                  oe_n = 1'b0;
    wire  [OUT_W-1:0]      d_o;
    wire                   ovr_o;
    wire                   dav_o;
    wire                   bus_drv;

    int checks = 0;
    int errors = 0;

    always #(CLK_P/2) clk = ~clk;

    interleave_result_mux uut (
        .clk(clk), .rst(rst), .sec_res(sec_res), .xfer(xfer), .xfer_idx(xfer_idx),
        .oe_n(oe_n), .d_o(d_o), .ovr_o(ovr_o), .dav_o(dav_o), .bus_drv(bus_drv)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int sval(input int mode, input int j);
        case (mode)
            0: return (j * 29 + 3) % 256;
            1: case (j % 4)
                   0: return 255;
                   1: return 256;
                   2: return 511;
                   default: return (j * 7) % 256;
               endcase
            default: return (j * 53 + 11) % 512;
        endcase
    endfunction

    task automatic do_reset();
        rst = 1'b1; xfer = 1'b0; oe_n = 1'b0; sec_res = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // streams NSAMP samples; sample j is transferred in cycle j+delay
    task automatic run_stream(input string req, input int mode, input int delay,
                              input int skip, input int oe_lo, input int oe_hi);
        int pb = 0;
        int po = 0;
        do_reset();
        for (int c = 0; c < NSAMP + LAT; c++) begin
            int j = c - delay;
            int k = c - LAT;
            oe_n = (c >= oe_lo && c < oe_hi);
            if (j >= 0 && j < NSAMP && j != skip) begin
                xfer = 1'b1;
                xfer_idx = 4'(j % NSEC);
                sec_res[(j % NSEC)*RES_W +: RES_W] = RES_W'(sval(mode, j));
            end else begin
                xfer = 1'b0;
            end
            #1;
            chk(req, "bus_drv", int'(bus_drv), int'(!oe_n));
            if (k < 0) begin
                chk({req, " R2"}, "dav in fill", int'(dav_o), 0);
                if (!oe_n) chk({req, " R2"}, "byte in fill", int'(d_o), 0);
            end else if (k == skip) begin
                chk({req, " R8"}, "dav on missing", int'(dav_o), 0);
                if (!oe_n) begin
                    chk({req, " R8"}, "byte held", int'(d_o), pb);
                    chk({req, " R8"}, "ovr held", int'(ovr_o), po);
                end
            end else begin
                int v = sval(mode, k);
                pb = (v > 255) ? 255 : v;
                po = (v > 255) ? 1 : 0;
                chk({req, " R7"}, "dav", int'(dav_o), 1);
                if (!oe_n) begin
                    chk(req, "byte", int'(d_o), pb);
                    chk(req, "ovr", int'(ovr_o), po);
                end
            end
            @(negedge clk);
        end
        xfer = 1'b0;
        oe_n = 1'b0;
    endtask

    task automatic t_reset_state();
        rst = 1'b1; oe_n = 1'b0; xfer = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R1", "dav in reset", int'(dav_o), 0);
        chk("R1", "byte in reset", int'(d_o), 0);
        chk("R1", "ovr in reset", int'(ovr_o), 0);
        rst = 1'b0;
        #1;
        chk("R1", "dav after reset", int'(dav_o), 0);
        chk("R1", "byte after reset", int'(d_o), 0);
    endtask

    task automatic t_stream_inrange();  run_stream("R2 R3", 0, 6, -1, -1, -1); endtask
    task automatic t_late_bypass();     run_stream("R5 R3 R4", 2, LAT - 1, -1, -1, -1); endtask
    task automatic t_early_xfer();      run_stream("R5", 2, 0, -1, -1, -1); endtask
    task automatic t_overrange();       run_stream("R4", 1, 8, -1, -1, -1); endtask
    task automatic t_missing();         run_stream("R8", 0, 5, 20, -1, -1); endtask
    task automatic t_enable();          run_stream("R6", 2, 7, -1, 15, 26); endtask

    initial begin
        #(CLK_P * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset_state();
        t_stream_inrange();
        t_late_bypass();
        t_early_xfer();
        t_overrange();
        t_missing();
        t_enable();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule